// File: doc/BRIEF.md
# Quadword Address Bus Drive and Snoop Capture Controller

This block decides when a processor puts its quadword address onto the shared system address bus, and when it lets go of the bus so that other masters can use it. The bus carries address bits 31 down to 3, which is 29 lines. Bits 2 to 0 are never driven, because every bus cycle starts on an eight-byte boundary.

A bus cycle opens with a cycle-start strobe. The block then drives the address it latched in that clock. It keeps driving until the final ready it expects: one ready for a single transfer, four for a burst. The surrounding system can take the bus back in three ways, and each has its own timing:
- Address-hold and back-off remove the drive one clock after they arrive.
- Hold-acknowledge removes the drive in the same clock.

Back-off also cancels the cycle that was in progress.

While the bus is released, an external address strobe makes the block sample the upper 27 bus lines, bits 31 to 5. It presents that address for one clock as a snoop request. Reset, init and the stop-clock state silence the block completely.

Top module: `addr_bus_ctrl`

## Requirements
- R1: In the clock where `cyc_start` is high, the block is not halted and the bus is not floated, `addr_oe` is 1 in that same clock and `addr_out` equals `addr_in`.
- R2: The drive window counts readies from the clock after the strobe. It stays open through the clock of the expected final ready: the 1st when `burst`=0, the 4th when `burst`=1. `addr_oe` is 0 in the following clock unless a new strobe arrives.
- R3: When `ahold` or `boff` goes high, `addr_oe` falls one clock later. When both are low again, `addr_oe` may return one clock after the negation.
- R4: While `hlda` is 1, `addr_oe` is 0 in that same clock. A `cyc_start` seen while floated opens no cycle.
- R5: When `ext_strobe` is 1 and at least one of `ahold`, `boff` or `hlda` is 1, bus lines `bus_in[28:2]` are captured (pin bits 31..5). In that case `snoop_valid` is 1 for exactly the next clock, with `snoop_addr` equal to the captured bits.
- R6: An `ext_strobe` is ignored, and gives no `snoop_valid`, while `addr_oe` is 1 or while no hold input is active.
- R7: `boff` discards the remaining ready count. After back-off ends, readies do not restore the drive; only a new `cyc_start` does.
- R8: While `rst`, `init` or `stop_clk` is 1, `addr_oe` is 0 and nothing is captured. `init` and `stop_clk` also cancel an open cycle.
- R9: While `addr_oe` is 1, `addr_out` holds the address latched at the strobe even if `addr_in` changes. While `addr_oe` is 0, `addr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Initialise request, silences the bus |
| stop_clk | input | 1 | Stop-clock state indication |
| cyc_start | input | 1 | Cycle-start address strobe |
| burst | input | 1 | 1 = four-transfer burst, 0 = single transfer |
| addr_in | input | 29 | Quadword address from the core (bits 31..3) |
| rdy | input | 1 | Transfer ready from the system |
| ahold | input | 1 | Address-hold request |
| boff | input | 1 | Back-off request |
| hlda | input | 1 | Hold acknowledge |
| ext_strobe | input | 1 | External address strobe for inquiries |
| bus_in | input | 29 | Sampled bus lines (bits 31..3) |
| addr_oe | output | 1 | Output enable for the address drivers |
| addr_out | output | 29 | Address to drive (bits 31..3) |
| snoop_valid | output | 1 | One-clock inquiry pulse |
| snoop_addr | output | 27 | Captured inquiry address (bits 31..5) |

## Verification
Some rules are checked by the assertions on every clock:
- the same-clock float under hold-acknowledge;
- the one-clock-late float after address-hold or back-off;
- silence under reset, init and stop-clock;
- no capture while driving;
- continuity of the drive window until its last ready.

Other behaviour only the bench's scenarios can show. These are the exact number of readies that closes single and burst cycles, the re-drive clock after a hold drops, and the discarding of a back-off count. The value of each captured snoop address, and the holding of the strobe-cycle address while `addr_in` moves, are also left to the bench.

// File: rtl/abc_pkg.sv
package abc_pkg;
  // Expected number of ready responses for one bus cycle.
  function automatic int xfer_count(input logic is_burst, input int burst_len);
    return is_burst ? burst_len : 1;
  endfunction

  // Inquiry address is the bus word with its two low lines dropped.
  function automatic int snoop_width(input int bus_w);
    return bus_w - 2;
  endfunction
endpackage

// File: rtl/abc_hold_track.sv
module abc_hold_track (
  input  logic clk,
  input  logic halt,
  input  logic ahold,
  input  logic boff,
  input  logic hlda,
  output logic float_now,
  output logic hold_any
);
  logic ahold_q;
  logic boff_q;

  always_ff @(posedge clk) begin
    if (halt) begin
      ahold_q <= 1'b0;
      boff_q  <= 1'b0;
    end else begin
      ahold_q <= ahold;
      boff_q  <= boff;
    end
  end

  // Address-hold and back-off take effect one clock late, hold-acknowledge at once.
  assign float_now = ahold_q | boff_q | hlda;
  assign hold_any  = ahold | boff | hlda;
endmodule

// File: rtl/abc_drive_window.sv
module abc_drive_window #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic halt,
  input  logic abort,
  input  logic start_ok,
  input  logic is_burst,
  input  logic rdy,
  output logic open,
  output logic last_rdy
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic [CNT_W-1:0] remain;

  assign last_rdy = open & rdy & (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (halt || abort) begin
      open   <= 1'b0;
      remain <= '0;
    end else if (start_ok) begin
      open   <= 1'b1;
      remain <= CNT_W'(abc_pkg::xfer_count(is_burst, BURST_LEN));
    end else if (open && rdy) begin
      if (remain == CNT_W'(1)) open <= 1'b0;
      remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/abc_snoop_capture.sv
module abc_snoop_capture #(
  parameter int BUS_W = 29,
  localparam int SNP_W = abc_pkg::snoop_width(BUS_W)
) (
  input  logic             clk,
  input  logic             halt,
  input  logic             capture_ok,
  input  logic [BUS_W-1:0] bus_in,
  output logic             snoop_valid,
  output logic [SNP_W-1:0] snoop_addr
);
  always_ff @(posedge clk) begin
    if (halt) begin
      snoop_valid <= 1'b0;
      snoop_addr  <= '0;
    end else begin
      snoop_valid <= capture_ok;
      if (capture_ok) snoop_addr <= bus_in[BUS_W-1:BUS_W-SNP_W];
    end
  end
endmodule

// File: rtl/addr_bus_ctrl.sv
module addr_bus_ctrl #(
  parameter int BUS_W     = 29,
  parameter int BURST_LEN = 4,
  localparam int SNP_W    = abc_pkg::snoop_width(BUS_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             stop_clk,
  input  logic             cyc_start,
  input  logic             burst,
  input  logic [BUS_W-1:0] addr_in,
  input  logic             rdy,
  input  logic             ahold,
  input  logic             boff,
  input  logic             hlda,
  input  logic             ext_strobe,
  input  logic [BUS_W-1:0] bus_in,
  output logic             addr_oe,
  output logic [BUS_W-1:0] addr_out,
  output logic             snoop_valid,
  output logic [SNP_W-1:0] snoop_addr
);
  // Named internal events, also observed by the checker.
  logic halt;
  logic float_now;
  logic hold_any;
  logic start_ok;
  logic open;
  logic last_rdy;
  logic capture_ok;
  logic [BUS_W-1:0] addr_q;

  assign halt     = rst | init | stop_clk;
  assign start_ok = cyc_start & ~halt & ~float_now;
  assign addr_oe  = ~halt & ~float_now & (start_ok | open);
  assign capture_ok = hold_any & ext_strobe & ~addr_oe & ~halt;

  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (start_ok) addr_q <= addr_in;
  end

  assign addr_out = !addr_oe ? '0 : (start_ok ? addr_in : addr_q);

  abc_hold_track u_hold (
    .clk       (clk),
    .halt      (halt),
    .ahold     (ahold),
    .boff      (boff),
    .hlda      (hlda),
    .float_now (float_now),
    .hold_any  (hold_any)
  );

  abc_drive_window #(.BURST_LEN(BURST_LEN)) u_win (
    .clk      (clk),
    .halt     (halt),
    .abort    (boff),
    .start_ok (start_ok),
    .is_burst (burst),
    .rdy      (rdy),
    .open     (open),
    .last_rdy (last_rdy)
  );

  abc_snoop_capture #(.BUS_W(BUS_W)) u_snp (
    .clk         (clk),
    .halt        (halt),
    .capture_ok  (capture_ok),
    .bus_in      (bus_in),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr)
  );
endmodule

// File: rtl/addr_bus_ctrl_sva.sv
module addr_bus_ctrl_sva (
  input logic clk,
  input logic rst,
  input logic init,
  input logic stop_clk,
  input logic cyc_start,
  input logic ahold,
  input logic boff,
  input logic hlda,
  input logic ext_strobe,
  input logic addr_oe,
  input logic snoop_valid,
  input logic halt,
  input logic last_rdy
);
  AST_FLOAT_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ahold || boff) |=> !addr_oe) else $error("float after hold");            // R3
  AST_FLOAT_SAME_CLOCK: assert property (@(posedge clk) disable iff (rst)
    hlda |-> !addr_oe) else $error("float with hold-ack");                    // R4
  AST_WINDOW_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (addr_oe && !last_rdy && !ahold && !boff) |=> (addr_oe || hlda || halt))
    else $error("window closed early");                                       // R2
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (last_rdy && !cyc_start && !boff) |=> !addr_oe) else $error("window stays open"); // R2
  AST_SNOOP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |-> $past(ext_strobe && (ahold || boff || hlda)))
    else $error("snoop without strobe");                                      // R5
  AST_NO_SNOOP_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    addr_oe |=> !snoop_valid) else $error("snoop while driving");             // R6
  AST_QUIET_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    (init || stop_clk) |-> !addr_oe) else $error("drive while halted");       // R8
  AST_NO_SNOOP_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    (init || stop_clk) |=> !snoop_valid) else $error("capture while halted"); // R8
endmodule

bind addr_bus_ctrl addr_bus_ctrl_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .init        (init),
  .stop_clk    (stop_clk),
  .cyc_start   (cyc_start),
  .ahold       (ahold),
  .boff        (boff),
  .hlda        (hlda),
  .ext_strobe  (ext_strobe),
  .addr_oe     (addr_oe),
  .snoop_valid (snoop_valid),
  .halt        (halt),
  .last_rdy    (last_rdy)
);

// File: tb/addr_bus_ctrl_bench.sv
`timescale 1ns/1ps
module addr_bus_ctrl_bench;
  localparam int BW = 29;
  localparam int SW = BW - 2;

  logic clk = 1'b0;
  logic rst = 1'b1, init = 1'b0, stop_clk = 1'b0;
  logic cyc_start = 1'b0, burst = 1'b0, rdy = 1'b0;
  logic ahold = 1'b0, boff = 1'b0, hlda = 1'b0, ext_strobe = 1'b0;
  logic [BW-1:0] addr_in = '0, bus_in = '0;
  logic addr_oe, snoop_valid;
  logic [BW-1:0] addr_out;
  logic [SW-1:0] snoop_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [SW-1:0] exp_q[$];

  always #5 clk = ~clk;

  addr_bus_ctrl u_addr_bus_ctrl (
    .clk(clk), .rst(rst), .init(init), .stop_clk(stop_clk),
    .cyc_start(cyc_start), .burst(burst), .addr_in(addr_in), .rdy(rdy),
    .ahold(ahold), .boff(boff), .hlda(hlda), .ext_strobe(ext_strobe),
    .bus_in(bus_in), .addr_oe(addr_oe), .addr_out(addr_out),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Start a new cycle: pulse inputs return to idle, levels persist.
  task automatic go();
    @(posedge clk);
    #1;
    cyc_start = 1'b0; rdy = 1'b0; ext_strobe = 1'b0;
  endtask

  task automatic probe();
    #3;
  endtask

  // Driver side of the scoreboard: expected inquiry address from the pins.
  task automatic strobe_snoop(input logic [BW-1:0] v, input bit expect_it);
    ext_strobe = 1'b1;
    bus_in = v;
    if (expect_it) exp_q.push_back(v[BW-1:2]);
  endtask

  // Monitor side: every pulse must match the oldest expectation.
  always @(negedge clk) begin
    if (!rst && snoop_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6: got snoop %0h expected no snoop at %0t", snoop_addr, $time);
      end else begin
        logic [SW-1:0] e;
        e = exp_q.pop_front();
        if (snoop_addr !== e) begin
          n_fail++;
          $display("FAIL R5: got snoop %0h expected %0h at %0t", snoop_addr, e, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    probe();
    check("R8 reset oe", addr_oe, 0);
    check("R8 reset snoop", snoop_valid, 0);

    // Single transfer
    go(); cyc_start = 1; burst = 0; addr_in = 29'h0ABC_DEF; probe();
    check("R1 strobe oe", addr_oe, 1);
    check("R1 strobe addr", addr_out, 29'h0ABC_DEF);
    go(); rdy = 1; addr_in = 29'h1111111; probe();
    check("R2 single last ready", addr_oe, 1);
    check("R9 latched addr", addr_out, 29'h0ABC_DEF);
    go(); probe();
    check("R2 single closed", addr_oe, 0);
    check("R9 idle zero", addr_out, 0);

    // Burst with a wait state
    go(); cyc_start = 1; burst = 1; addr_in = 29'h1234567; probe();
    check("R1 burst strobe", addr_oe, 1);
    go(); rdy = 1; addr_in = 29'h0000042; probe();
    check("R9 burst holds addr", addr_out, 29'h1234567);
    go(); rdy = 1; probe();
    go(); probe();
    check("R2 wait state open", addr_oe, 1);
    go(); rdy = 1; probe();
    check("R2 third ready open", addr_oe, 1);
    go(); rdy = 1; probe();
    check("R2 fourth ready open", addr_oe, 1);
    go(); probe();
    check("R2 burst closed", addr_oe, 0);

    // Address-hold mid burst with inquiry
    go(); cyc_start = 1; burst = 1; addr_in = 29'h0F0F0F0; probe();
    go(); rdy = 1; ahold = 1; strobe_snoop(29'h1FFFFFF, 0); probe();
    check("R3 ahold first clock driven", addr_oe, 1);
    go(); strobe_snoop(29'h15A5A5C, 1); probe();
    check("R3 ahold floats", addr_oe, 0);
    check("R6 strobe while driving gave no snoop", snoop_valid, 0);
    go(); probe();
    check("R3 ahold still floated", addr_oe, 0);
    go(); ahold = 0; probe();
    check("R3 negation clock floated", addr_oe, 0);
    go(); probe();
    check("R3 re-driven", addr_oe, 1);
    check("R9 re-driven addr", addr_out, 29'h0F0F0F0);
    go(); rdy = 1; probe();
    go(); rdy = 1; probe();
    go(); rdy = 1; probe();
    check("R2 final ready after hold", addr_oe, 1);
    go(); probe();
    check("R2 closed after hold", addr_oe, 0);

    // Strobe with no hold is ignored
    go(); strobe_snoop(29'h0777777, 0); probe();
    go(); probe();
    check("R6 no hold no snoop", snoop_valid, 0);

    // Hold-acknowledge
    go(); hlda = 1; cyc_start = 1; burst = 0; addr_in = 29'h0000100;
    strobe_snoop(29'h0ABCDE4, 1); probe();
    check("R4 hlda same clock", addr_oe, 0);
    go(); hlda = 0; probe();
    check("R4 strobe while floated ignored", addr_oe, 0);
    go(); cyc_start = 1; burst = 0; addr_in = 29'h0000200; probe();
    check("R1 single again", addr_oe, 1);
    go(); hlda = 1; probe();
    check("R4 hlda mid cycle", addr_oe, 0);
    go(); hlda = 0; rdy = 1; probe();
    check("R4 cycle resumes", addr_oe, 1);
    go(); probe();
    check("R2 closed after hlda", addr_oe, 0);

    // Back-off mid burst
    go(); cyc_start = 1; burst = 1; addr_in = 29'h0333333; probe();
    go(); rdy = 1; probe();
    go(); boff = 1; probe();
    check("R3 boff first clock driven", addr_oe, 1);
    go(); strobe_snoop(29'h1000008, 1); probe();
    check("R3 boff floats", addr_oe, 0);
    go(); boff = 0; probe();
    go(); rdy = 1; probe();
    check("R7 count discarded", addr_oe, 0);
    go(); rdy = 1; probe();
    check("R7 still released", addr_oe, 0);
    go(); cyc_start = 1; burst = 0; addr_in = 29'h0444444; probe();
    check("R7 new strobe drives", addr_oe, 1);
    go(); rdy = 1; probe();
    go(); probe();
    check("R7 new cycle closed", addr_oe, 0);

    // Init and stop-clock
    go(); cyc_start = 1; burst = 0; addr_in = 29'h0555555; probe();
    go(); init = 1; probe();
    check("R8 init floats", addr_oe, 0);
    go(); init = 0; rdy = 1; probe();
    check("R8 init cancelled cycle", addr_oe, 0);
    go(); init = 1; cyc_start = 1; probe();
    check("R8 strobe under init", addr_oe, 0);
    go(); ahold = 1; strobe_snoop(29'h1234560, 0); probe();
    go(); init = 0; ahold = 0; probe();
    check("R8 no capture under init", snoop_valid, 0);
    go(); stop_clk = 1; cyc_start = 1; probe();
    check("R8 stop clock silent", addr_oe, 0);
    go(); stop_clk = 0; probe();
    go(); probe();

    check("R5 all snoops seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule